// File: doc/BRIEF.md
# Ring-Chained FIFO Depth Expander

This block builds one deep first-in/first-out buffer out of a ring of identical storage slices. Each slice owns a small memory with its own write and read pointers. Two tokens travel around the ring: the write token marks the slice that accepts the next word, and the read token marks the slice that delivers the next word. When the token holder uses the last physical location of its memory, it raises an expansion pulse on its output. The next slice in the ring (the last wraps to the first) takes that token on the same clock edge.

The write strobe, write data, read strobe and read data are shared by every slice. A slice that lacks the matching token ignores a strobe and keeps its data output at zero with its valid low. The per-slice full and empty indications are qualified by token ownership and then OR-combined at the top. This gives a composite full and empty for a buffer of `N_SLICES * SLICE_DEPTH` words. All logic runs on one clock with a synchronous active-high reset. The slice chosen by `LEAD_SLICE` is the one whose first-load input is active, and it starts with both tokens.

Top module: `fifo_chain`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `empty` is 1, `full` is 0 and `rd_valid` is 0; a reset in the middle of operation discards all stored words.
- R2: Words are read out in the order they were accepted, including across slice boundaries and across the wrap from the last slice back to the lead slice.
- R3: With no reads, `full` rises after exactly `N_SLICES*SLICE_DEPTH` accepted writes; writes presented while `full` is 1 and no read is accepted are dropped and never appear at `rd_data`.
- R4: A read strobe while `empty` is 1 is ignored: `rd_valid` stays 0 on the next cycle and no stored word is lost.
- R5: A read accepted at a clock edge (`rd_en` high and `empty` low) gives `rd_valid` = 1 with the word on `rd_data` right after that edge; otherwise `rd_valid` is 0 and `rd_data` is 0.
- R6: `empty` and `full` reflect the occupancy after each edge: `empty` is 1 exactly when zero words are held, and `full` is 1 exactly when `N_SLICES*SLICE_DEPTH` words are held.
- R7: With simultaneous write and read while neither flag is set, both are accepted and occupancy is unchanged.
- R8: With simultaneous write and read while `full` is 1, the read is accepted and the write is dropped.
- R9: Exactly one slice holds the write token and exactly one holds the read token at all times after reset.
- R10: With simultaneous write and read while `empty` is 1, the write is accepted and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | DATA_W | Write data shared by all slices |
| full | output | 1 | Composite full |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| empty | output | 1 | Composite empty |

## Verification
A lost or duplicated token leaves a slice that answers a strobe out of turn, or leaves no slice at all. At the ports, this appears as a wrong or missing word the first time the data stream crosses a slice boundary. So an error shows at most `SLICE_DEPTH` accesses after the fault. A wrong occupancy counter inside one slice shows up on the composite `full` or `empty` flag in the same cycle that the token holder reaches that slice. An off-by-one in a last-location compare shows up as a skipped or repeated word at the wrap point.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Expansion pulses carried from one slice to the next in the ring
  typedef struct packed {
    logic wr;  // write token handed over
    logic rd;  // read token handed over
  } xpulse_t;
endpackage

// File: rtl/fifo_chain_ram.sv
module fifo_chain_ram #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_chain_merge.sv
module fifo_chain_merge #(
  parameter int N = 3,
  parameter int W = 9
) (
  input  logic [N-1:0][W-1:0] lanes,
  output logic [W-1:0]        merged
);
  always_comb begin
    merged = '0;
    for (int k = 0; k < N; k++) merged = merged | lanes[k];
  end
endmodule

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_load,
  input  xpulse_t           xin,
  output xpulse_t           xout,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              slice_full,
  output logic              slice_empty,
  output logic              wr_tok,
  output logic              rd_tok
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     fill;
  logic              wr_acc, rd_acc, wr_last, rd_last;
  logic              vld_q;
  logic [DATA_W-1:0] ram_q;

  assign wr_last = (wptr == LAST);
  assign rd_last = (rptr == LAST);
  assign wr_acc  = wr_tok & wr_en & (fill != CAP);
  assign rd_acc  = rd_tok & rd_en & (fill != '0);

  assign xout.wr = wr_acc & wr_last;
  assign xout.rd = rd_acc & rd_last;

  assign slice_full  = wr_tok & (fill == CAP);
  assign slice_empty = rd_tok & (fill == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_tok <= first_load;
      rd_tok <= first_load;
      wptr   <= '0;
      rptr   <= '0;
      fill   <= '0;
      vld_q  <= 1'b0;
    end else begin
      wr_tok <= (wr_tok & ~xout.wr) | xin.wr;
      rd_tok <= (rd_tok & ~xout.rd) | xin.rd;
      if (wr_acc) wptr <= wr_last ? '0 : wptr + 1'b1;
      if (rd_acc) rptr <= rd_last ? '0 : rptr + 1'b1;
      case ({wr_acc, rd_acc})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      vld_q <= rd_acc;
    end
  end

  fifo_chain_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (wr_acc),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (rd_acc),
    .raddr (rptr),
    .rdata (ram_q)
  );

  assign rd_valid = vld_q;
  assign rd_data  = vld_q ? ram_q : '0;
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int N_SLICES    = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int DATA_W      = 9,
  parameter int LEAD_SLICE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty
);
  xpulse_t                      xo_vec [N_SLICES];
  logic [N_SLICES-1:0][DATA_W-1:0] data_lanes;
  logic [N_SLICES-1:0]          vld_vec, full_vec, empty_vec;
  logic [N_SLICES-1:0]          wr_tok_vec, rd_tok_vec;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    localparam int PREV = (k == 0) ? N_SLICES - 1 : k - 1;
    fifo_chain_slice #(.DEPTH(SLICE_DEPTH), .DATA_W(DATA_W)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .first_load  (k == LEAD_SLICE),
      .xin         (xo_vec[PREV]),
      .xout        (xo_vec[k]),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_data     (data_lanes[k]),
      .rd_valid    (vld_vec[k]),
      .slice_full  (full_vec[k]),
      .slice_empty (empty_vec[k]),
      .wr_tok      (wr_tok_vec[k]),
      .rd_tok      (rd_tok_vec[k])
    );
  end

  fifo_chain_merge #(.N(N_SLICES), .W(DATA_W)) u_merge (
    .lanes  (data_lanes),
    .merged (rd_data)
  );

  assign rd_valid = |vld_vec;
  assign full     = |full_vec;
  assign empty    = |empty_vec;
endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int N_SLICES = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic                full,
  input logic                empty,
  input logic                rd_valid,
  input logic [N_SLICES-1:0] wr_tok,
  input logic [N_SLICES-1:0] rd_tok
);
  // R1
  reset_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && !full && !rd_valid));

  // R5
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  // R5
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !empty) |=> !rd_valid);

  // R4
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty);

  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R9
  one_wr_token_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_tok) == 1);

  // R9
  one_rd_token_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_tok) == 1);
endmodule

bind fifo_chain fifo_chain_chk #(.N_SLICES(N_SLICES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .full     (full),
  .empty    (empty),
  .rd_valid (rd_valid),
  .wr_tok   (wr_tok_vec),
  .rd_tok   (rd_tok_vec)
);

// File: tb/tb_fifo_chain.sv
module tb_fifo_chain;
  localparam int N   = 3;
  localparam int D   = 4;
  localparam int W   = 9;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, full, empty;

  always #2.5 clk = ~clk;

  fifo_chain #(.N_SLICES(N), .SLICE_DEPTH(D), .DATA_W(W), .LEAD_SLICE(0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty)
  );

  int           n_chk = 0, n_fail = 0;
  int           cnt = 0;
  bit           pend_rd = 1'b0;
  logic [W-1:0] sb [$];
  string        phase = "R1";
  int           dv = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, scoreboard push on accepted writes
  task automatic step(input bit w, input bit r);
    @(negedge clk);
    wr_en   = w;
    rd_en   = r;
    wr_data = W'(dv);
    pend_rd = r && (cnt != 0);
    if (w && (cnt != CAP)) begin
      sb.push_back(W'(dv));
      cnt++;
    end
    if (pend_rd) cnt--;
    dv++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    pend_rd = 1'b0; cnt = 0; sb.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: sample after each edge, pop and compare
  initial begin
    @(posedge clk);
    forever begin
      @(posedge clk);
      #1;
      check(rd_valid === pend_rd, {"R5 valid ", phase}, int'(rd_valid), int'(pend_rd));
      if (rd_valid === 1'b1) begin
        if (sb.size() == 0) check(1'b0, {"R2 extra word ", phase}, int'(rd_data), -1);
        else begin
          logic [W-1:0] e;
          e = sb.pop_front();
          check(rd_data === e, {"R2 order ", phase}, int'(rd_data), int'(e));
        end
      end else begin
        check(rd_data === '0, {"R5 idle data ", phase}, int'(rd_data), 0);
      end
      check(empty === (cnt == 0), {"R6 empty ", phase}, int'(empty), int'(cnt == 0));
      check(full === (cnt == CAP), {"R3 full ", phase}, int'(full), int'(cnt == CAP));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state after reset release
    check(empty === 1'b1, "R1 empty after reset", int'(empty), 1);
    check(full === 1'b0, "R1 full after reset", int'(full), 0);
    check(rd_valid === 1'b0, "R1 valid after reset", int'(rd_valid), 0);

    phase = "R2 cross slice";
    for (int i = 0; i < 5; i++) step(1, 0);
    for (int i = 0; i < 6; i++) step(0, 1);

    phase = "R3 fill";
    for (int i = 0; i < CAP + 3; i++) step(1, 0);
    phase = "R8 both at full";
    step(1, 1);
    step(1, 0);
    phase = "R2 drain with wrap";
    for (int i = 0; i < CAP + 1; i++) step(0, 1);
    phase = "R4 read on empty";
    step(0, 1);
    step(0, 1);
    phase = "R10 both at empty";
    step(1, 1);
    step(0, 0);
    phase = "R7 streaming R9 ring laps";
    step(1, 0);
    step(1, 0);
    for (int i = 0; i < 3 * CAP; i++) step(1, 1);
    for (int i = 0; i < 5; i++) step(0, 1);

    phase = "R1 mid reset";
    for (int i = 0; i < 7; i++) step(1, 0);
    do_reset();
    @(negedge clk);
    check(empty === 1'b1, "R1 empty after mid reset", int'(empty), 1);
    check(rd_valid === 1'b0, "R1 valid after mid reset", int'(rd_valid), 0);
    phase = "R2 after reset";
    for (int i = 0; i < 6; i++) step(1, 0);
    for (int i = 0; i < 7; i++) step(0, 1);
    step(0, 0);
    step(0, 0);
    check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule